// File: doc/BRIEF.md
# Quadtree Nonzero Activation Streamer

The block holds one activation vector in a local register bank and streams out only its nonzero entries, one per accepted transfer, each tagged with its absolute position in the vector. Zero entries cost no cycles at all. A radix-4 selection tree finds the pending nonzero entries. Each node of the tree looks at four children and passes the first one that holds a candidate up to its parent. The root drives a single valid/ready output port, which any number of downstream consumers can share.

A new vector is captured with a one-cycle load strobe. Each entry carries a pending bit, and a completed handshake clears the bit of the entry just sent, so the next nonzero entry reaches the root in the following cycle. When no pending nonzero entry remains, the block raises a done flag in place of valid. A vector that is entirely zero therefore reports done straight after its load.

Top module: `nzt_top`

## Requirements
- R1: A load strobe captures the whole vector and marks every entry pending. Entry i occupies bits [i*DATA_W +: DATA_W] of the input bus. The first result appears on the output in the cycle after the load edge.
- R2: A zero-valued entry is never presented. Whenever valid is high, the value output is nonzero.
- R3: When several pending nonzero entries exist, the one with the lowest index is presented first. Successive emissions of one vector therefore have strictly rising indices.
- R4: The index output equals the absolute entry position i (0 to 63 by default). Its two top bits are the root node's child select, and each lower bit pair is the select one tree level further down. The value output equals entry i of the loaded vector.
- R5: A clock edge with valid and ready both high retires the presented entry. The next pending nonzero entry, if any, is presented in the following cycle.
- R6: While valid is high and ready is low, valid stays high, and index and value hold steady until the handshake completes.
- R7: Done is high and valid is low exactly when a vector has been loaded and no pending nonzero entry remains. An all-zero vector shows done in the first cycle after its load.
- R8: After reset, and until the first load, both valid and done are low.
- R9: A load in the same cycle as a handshake takes priority. The new vector starts with every entry pending, and it is presented from its lowest nonzero entry.
- R10: Holding ready high while done is set changes nothing. Done stays high and valid stays low until the next load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Capture vec_i and re-arm all entries |
| vec_i | input | ENTRIES*DATA_W | Activation vector, entry i at [i*DATA_W +: DATA_W] |
| ready_i | input | 1 | Consumer accepts the presented entry |
| valid_o | output | 1 | A nonzero entry is presented |
| value_o | output | DATA_W | Value of the presented entry |
| index_o | output | 2*LEVELS | Absolute position of the presented entry |
| done_o | output | 1 | Loaded vector fully streamed |

## Verification
The assertions check several properties on every cycle. A presented value is never zero. Valid and done never rise together. A stalled output holds its index and value. A handshake clears that entry's pending bit. Indices rise between emissions of one vector. A load re-arms every pending bit. Only the bench's scenarios can show that the streamed sequence is complete, with every nonzero entry sent exactly once and at the right position. The same holds for the effect of a load that collides with a handshake, and for the all-zero, single-entry and fully dense vectors.

// File: rtl/nzt_pkg.sv
package nzt_pkg;

  typedef logic [1:0] sel_t;

  // Fixed-priority pick among four child hit flags, lowest child first.
  function automatic sel_t pick4(input logic [3:0] hit);
    sel_t s;
    if (hit[0])      s = 2'd0;
    else if (hit[1]) s = 2'd1;
    else if (hit[2]) s = 2'd2;
    else             s = 2'd3;
    return s;
  endfunction

endpackage

// File: rtl/nzt_node.sv
module nzt_node
  import nzt_pkg::*;
#(
  parameter int IDX_W = 6,
  parameter int SHIFT = 0
) (
  input  logic [3:0]       hit_i,
  input  logic [IDX_W-1:0] idx_i [4],
  output logic             hit_o,
  output logic [IDX_W-1:0] idx_o
);

  sel_t sel;

  always_comb begin
    sel   = pick4(hit_i);
    hit_o = |hit_i;
    // The child's partial index gets this level's select placed above it.
    idx_o = idx_i[sel] | (IDX_W'(sel) << SHIFT);
  end

endmodule

// File: rtl/nzt_tree.sv
module nzt_tree #(
  parameter int LEVELS = 3,
  localparam int ENTRIES = 1 << (2 * LEVELS),
  localparam int IDX_W = 2 * LEVELS
) (
  input  logic [ENTRIES-1:0] cand_i,
  output logic               hit_o,
  output logic [IDX_W-1:0]   idx_o
);

  for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
    localparam int CNT = ENTRIES >> (2 * (l + 1));
    logic [CNT-1:0]   hit;
    logic [IDX_W-1:0] idx [CNT];

    for (genvar k = 0; k < CNT; k++) begin : g_node
      logic [3:0]       ch_hit;
      logic [IDX_W-1:0] ch_idx [4];

      if (l == 0) begin : g_leaf
        assign ch_hit = cand_i[4*k +: 4];
        for (genvar j = 0; j < 4; j++) begin : g_ch
          assign ch_idx[j] = '0;
        end
      end else begin : g_inner
        assign ch_hit = g_lvl[l-1].hit[4*k +: 4];
        for (genvar j = 0; j < 4; j++) begin : g_ch
          assign ch_idx[j] = g_lvl[l-1].idx[4*k+j];
        end
      end

      nzt_node #(
        .IDX_W (IDX_W),
        .SHIFT (2 * l)
      ) u_node (
        .hit_i (ch_hit),
        .idx_i (ch_idx),
        .hit_o (hit[k]),
        .idx_o (idx[k])
      );
    end
  end

  assign hit_o = g_lvl[LEVELS-1].hit[0];
  assign idx_o = g_lvl[LEVELS-1].idx[0];

endmodule

// File: rtl/nzt_bank.sv
module nzt_bank #(
  parameter int LEVELS = 3,
  parameter int DATA_W = 8,
  localparam int ENTRIES = 1 << (2 * LEVELS),
  localparam int IDX_W = 2 * LEVELS,
  localparam int VEC_W = ENTRIES * DATA_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [VEC_W-1:0]   vec_i,
  input  logic               retire_i,
  input  logic [IDX_W-1:0]   retire_idx_i,
  output logic [VEC_W-1:0]   vec_o,
  output logic [ENTRIES-1:0] cand_o,
  output logic               have_o
);

  logic [VEC_W-1:0]   vec_q;
  logic [ENTRIES-1:0] live_q, live_d;
  logic               have_q, have_d;
  logic               live_en;

  // Next-state logic: a load wins over a retire in the same cycle.
  always_comb begin
    live_d  = live_q;
    live_en = load_i | retire_i;
    if (load_i) begin
      live_d = '1;
    end else if (retire_i) begin
      live_d[retire_idx_i] = 1'b0;
    end
    have_d = have_q | load_i;
  end

  // Data bank: clock enable is the load strobe, no reset needed on data.
  always_ff @(posedge clk_i) begin
    if (load_i) vec_q <= vec_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      live_q <= '0;
      have_q <= 1'b0;
    end else begin
      if (live_en) live_q <= live_d;
      have_q <= have_d;
    end
  end

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cand
    assign cand_o[i] = live_q[i] & (|vec_q[i*DATA_W +: DATA_W]);
  end

  assign vec_o  = vec_q;
  assign have_o = have_q;

  // R5: a retired entry is no longer pending one cycle later.
  a_r5_retire_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (retire_i && !load_i) |=> !live_q[$past(retire_idx_i)]);

  // R1/R9: a load re-arms every entry.
  a_r9_load_rearms: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (&live_q));

endmodule

// File: rtl/nzt_top.sv
module nzt_top #(
  parameter int LEVELS = 3,
  parameter int DATA_W = 8,
  localparam int ENTRIES = 1 << (2 * LEVELS),
  localparam int IDX_W = 2 * LEVELS,
  localparam int VEC_W = ENTRIES * DATA_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [VEC_W-1:0] vec_i,
  input  logic             ready_i,
  output logic             valid_o,
  output logic [DATA_W-1:0] value_o,
  output logic [IDX_W-1:0] index_o,
  output logic             done_o
);

  logic [VEC_W-1:0]   vec_q;
  logic [ENTRIES-1:0] cand;
  logic               have;
  logic               hit;
  logic [IDX_W-1:0]   win_idx;
  logic               fire;

  assign fire = valid_o & ready_i;

  nzt_bank #(
    .LEVELS (LEVELS),
    .DATA_W (DATA_W)
  ) u_bank (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (load_i),
    .vec_i        (vec_i),
    .retire_i     (fire),
    .retire_idx_i (win_idx),
    .vec_o        (vec_q),
    .cand_o       (cand),
    .have_o       (have)
  );

  nzt_tree #(
    .LEVELS (LEVELS)
  ) u_tree (
    .cand_i (cand),
    .hit_o  (hit),
    .idx_o  (win_idx)
  );

  assign valid_o = have & hit;
  assign done_o  = have & ~hit;
  assign index_o = win_idx;
  assign value_o = vec_q[win_idx*DATA_W +: DATA_W];

  // R2: never present a zero value.
  a_r2_value_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (value_o != '0));

  // R7: valid and done are exclusive.
  a_r7_valid_done_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_o && done_o));

  // R6: a stalled output holds.
  a_r6_stall_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i && !load_i) |=>
      (valid_o && $stable(index_o) && $stable(value_o)));

  // R3: emissions of one vector rise in index.
  a_r3_rising_index: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && !load_i) |=> (!valid_o || (index_o > $past(index_o))));

  // R10: done persists until a load.
  a_r10_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !load_i) |=> done_o);

endmodule

// File: tb/nzt_top_tb_top.sv
module nzt_top_tb_top;

  localparam int LEVELS  = 3;
  localparam int DATA_W  = 8;
  localparam int ENTRIES = 1 << (2 * LEVELS);
  localparam int IDX_W   = 2 * LEVELS;
  localparam int VEC_W   = ENTRIES * DATA_W;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              load;
  logic [VEC_W-1:0]  vec;
  logic              ready;
  logic              valid;
  logic [DATA_W-1:0] value;
  logic [IDX_W-1:0]  index;
  logic              done;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  logic [DATA_W-1:0] ref_v [ENTRIES];
  int pos;

  always #10 clk = ~clk;

  nzt_top #(.LEVELS(LEVELS), .DATA_W(DATA_W)) dut_i (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .load_i  (load),
    .vec_i   (vec),
    .ready_i (ready),
    .valid_o (valid),
    .value_o (value),
    .index_o (index),
    .done_o  (done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int next_nz(input int from);
    for (int i = from; i < ENTRIES; i++)
      if (ref_v[i] != '0) return i;
    return ENTRIES;
  endfunction

  task automatic fill(input int pct);
    for (int i = 0; i < ENTRIES; i++)
      ref_v[i] = ($urandom_range(99) < pct) ? DATA_W'($urandom_range(255, 1)) : '0;
  endtask

  // Drive load at a negedge; the first result is sampled at the next negedge.
  task automatic do_load();
    for (int i = 0; i < ENTRIES; i++) vec[i*DATA_W +: DATA_W] = ref_v[i];
    load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    pos = next_nz(0);
  endtask

  task automatic compare(input string req);
    bit ev = (pos < ENTRIES);
    check(valid == ev, req, "valid", int'(valid), int'(ev));
    check(done == !ev, "R7", "done", int'(done), int'(!ev));
    if (ev) begin
      check(index == IDX_W'(pos), "R4", "index", int'(index), pos);
      check(value == ref_v[pos], "R2", "value", int'(value), int'(ref_v[pos]));
    end
  endtask

  // Stream the whole vector with a random ready pattern.
  task automatic stream(input int ready_pct);
    bit stalled = 1'b0;
    while (1) begin
      ready = ($urandom_range(99) < ready_pct);
      compare(stalled ? "R6" : "R3");
      if (pos >= ENTRIES) break;
      @(negedge clk);
      stalled = !ready;
      if (ready) pos = next_nz(pos + 1);
    end
    // R10: ready high while done is set changes nothing.
    ready = 1'b1;
    @(negedge clk);
    check(done == 1'b1 && valid == 1'b0, "R10", "done held", int'(done), 1);
  endtask

  initial begin
    while (cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    n_fail++;
    $display("FAIL R1 watchdog expired: actual %0d expected %0d", cycles, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; load = 1'b0; ready = 1'b0; vec = '0;
    repeat (3) @(negedge clk);
    check(valid == 0 && done == 0, "R8", "in reset", int'(valid | done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    ready = 1'b1;
    @(negedge clk);
    check(valid == 0 && done == 0, "R8", "before load", int'(valid | done), 0);

    // R7: all-zero vector gives done at once.
    for (int i = 0; i < ENTRIES; i++) ref_v[i] = '0;
    do_load();
    check(done == 1'b1 && valid == 1'b0, "R7", "all zero", int'(done), 1);
    stream(100);

    // R4: single entries at the edges and inside.
    ref_v[ENTRIES-1] = 8'h5a;
    do_load();
    check(index == IDX_W'(ENTRIES-1), "R4", "top index", int'(index), ENTRIES-1);
    stream(100);
    for (int i = 0; i < ENTRIES; i++) ref_v[i] = '0;
    ref_v[0] = 8'h01; ref_v[21] = 8'h80; ref_v[42] = 8'hff;
    do_load();
    check(index == '0, "R1", "first after load", int'(index), 0);
    stream(60);

    // R5: fully dense vector, one per cycle.
    for (int i = 0; i < ENTRIES; i++) ref_v[i] = DATA_W'(i + 1);
    do_load();
    stream(100);

    // R9: reload collides with a handshake mid-stream.
    fill(50);
    do_load();
    ready = 1'b1;
    repeat (3) begin
      if (valid) pos = next_nz(pos + 1);
      @(negedge clk);
    end
    fill(40);
    ref_v[2] = 8'h33;
    ready = 1'b1;
    do_load();
    check(index == IDX_W'(next_nz(0)), "R9", "reload restart", int'(index), next_nz(0));
    stream(70);

    // R3/R5/R6: random vectors with random back-pressure.
    for (int t = 0; t < 40; t++) begin
      fill($urandom_range(90, 5));
      do_load();
      stream($urandom_range(90, 20));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule